// File: doc/BRIEF.md
# Quadrature NCO and Mixer

This block produces a cosine and a sine at one programmable frequency from a phase accumulator. It multiplies each incoming real converter sample by both waves to give an in-phase (I) and a quadrature (Q) product. It is the first stage of a digital downconverter. The frequency tuning word sets how far the accumulator moves for each accepted sample. A separate phase offset word rotates the oscillator phase without changing its frequency.

The accumulator advances only when a sample is presented with its valid strobe. Its top bits address a sine table that is built at elaboration from a quarter-wave table. Cosine is read a quarter cycle ahead of sine. The table read and the two multipliers are each registered. The products are truncated and come out three cycles after the sample, with a matching valid strobe.

Top module: `nco_mix_top`

## Requirements
- R1: After reset, `out_valid` is 0, `out_i` and `out_q` are 0, and the phase accumulator is 0. The first sample after reset therefore uses the phase `phase_ofs`.
- R2: The I product is bits [31:14] of the 32-bit signed product `in_sample` × cos. The Q product is bits [31:14] of `in_sample` × sin. Both operands are 16-bit signed.
- R3: Each accepted sample (`in_valid`=1) uses the current accumulator value. After that sample, the accumulator grows by `ftw` modulo 2^32.
- R4: On cycles with `in_valid`=0, the accumulator holds its value whatever `ftw` and `phase_ofs` carry.
- R5: `out_valid` equals `in_valid` delayed by exactly 3 clock cycles, one output pulse per sample, including back-to-back samples.
- R6: The table index n is bits [31:22] of (accumulator + `phase_ofs`) mod 2^32. The offset is applied to each sample and is never accumulated.
- R7: sin(n) = round(32767·sin(2π(n+0.5)/1024)). cos(n) = sin((n+256) mod 1024).
- R8: `out_i` and `out_q` keep their last values on cycles when no new product is produced.
- R9: The full-scale sample values −32768 and +32767 at near-peak oscillator values give the exact truncated product, without wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample strobe; also advances the phase |
| in_sample | input | 16 | Signed converter sample |
| ftw | input | 32 | Frequency tuning word |
| phase_ofs | input | 32 | Phase offset word |
| out_valid | output | 1 | Product strobe |
| out_i | output | 18 | In-phase product |
| out_q | output | 18 | Quadrature product |

## Verification
The assertions check on every cycle that the accumulator holds when there is no sample and steps by exactly the tuning word when there is one. They also check that the output strobe trails the input strobe by three cycles, and that the products do not move between outputs. The table contents, the quadrant folding, the quarter-cycle cosine lead, the per-sample offset and the truncation field can only be seen in the product values. The bench compares those values against an independently computed sine model, for varied tuning words, offsets, extreme samples and a reset in mid-stream.

// File: rtl/nco_mix_pkg.sv
package nco_mix_pkg;

   // One quarter-wave entry, centred half a step into its bin so the four
   // quadrants fold onto it exactly.
   function automatic int qwave_val(int j, int qdepth, int amp_w);
      real peak;
      real ang;
      real r;
      peak = (2.0 ** (amp_w - 1)) - 1.0;
      ang  = 3.14159265358979 * (j + 0.5) / (2.0 * qdepth);
      r    = peak * $sin(ang);
      return (r >= 0.0) ? $rtoi(r + 0.5) : $rtoi(r - 0.5);
   endfunction

endpackage

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
   parameter int PHASE_W = 32,
   parameter int ADDR_W  = 10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               step_en,
   input  logic [PHASE_W-1:0] ftw,
   input  logic [PHASE_W-1:0] ofs,
   output logic [PHASE_W-1:0] acc_q,
   output logic [ADDR_W-1:0]  addr
);
   logic [PHASE_W-1:0] phase_now;

   always_ff @(posedge clk) begin
      if (!rst_n)       acc_q <= '0;
      else if (step_en) acc_q <= acc_q + ftw;
   end

   assign phase_now = acc_q + ofs;
   assign addr      = phase_now[PHASE_W-1 -: ADDR_W];
endmodule

// File: rtl/nco_sine_lut.sv
module nco_sine_lut #(
   parameter int ADDR_W = 10,
   parameter int AMP_W  = 16,
   parameter int SHIFT  = 0
) (
   input  logic [ADDR_W-1:0]       addr,
   output logic signed [AMP_W-1:0] value
);
   localparam int QW = ADDR_W - 2;
   localparam int QD = 1 << QW;

   logic signed [AMP_W-1:0] qtab [QD];
   logic [ADDR_W-1:0]       idx;
   logic [1:0]              quad;
   logic [QW-1:0]           j;
   logic signed [AMP_W-1:0] mag;

   for (genvar t = 0; t < QD; t++) begin : g_tab
      localparam int V = nco_mix_pkg::qwave_val(t, QD, AMP_W);
      assign qtab[t] = AMP_W'(V);
   end

   assign idx  = addr + ADDR_W'(SHIFT);
   assign quad = idx[ADDR_W-1 -: 2];
   assign j    = idx[QW-1:0];

   always_comb begin
      mag   = quad[0] ? qtab[~j] : qtab[j];
      value = quad[1] ? -mag : mag;
   end
endmodule

// File: rtl/nco_mix_lane.sv
module nco_mix_lane #(
   parameter int SMP_W = 16,
   parameter int AMP_W = 16,
   parameter int OUT_W = 18
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    en,
   input  logic signed [SMP_W-1:0] sample,
   input  logic signed [AMP_W-1:0] osc,
   output logic [OUT_W-1:0]        prod_q
);
   localparam int PROD_W = SMP_W + AMP_W;

   logic signed [PROD_W-1:0] full;

   assign full = PROD_W'(sample) * PROD_W'(osc);

   always_ff @(posedge clk) begin
      if (!rst_n)  prod_q <= '0;
      else if (en) prod_q <= full[PROD_W-1 -: OUT_W];
   end
endmodule

// File: rtl/nco_mix_top.sv
module nco_mix_top #(
   parameter int PHASE_W = 32,
   parameter int ADDR_W  = 10,
   parameter int SMP_W   = 16,
   parameter int AMP_W   = 16,
   parameter int OUT_W   = 18
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [SMP_W-1:0] in_sample,
   input  logic [PHASE_W-1:0] ftw,
   input  logic [PHASE_W-1:0] phase_ofs,
   output logic             out_valid,
   output logic [OUT_W-1:0] out_i,
   output logic [OUT_W-1:0] out_q
);
   localparam int N_LANES = 2;
   localparam int QUARTER = (1 << ADDR_W) / 4;

   if (ADDR_W < 3 || ADDR_W > PHASE_W) begin : g_bad_addr
      $error("nco_mix_top: ADDR_W must lie in 3..PHASE_W");
   end
   if (OUT_W > SMP_W + AMP_W) begin : g_bad_out
      $error("nco_mix_top: OUT_W exceeds the product width");
   end

   logic [PHASE_W-1:0]      acc;
   logic [ADDR_W-1:0]       addr_now;
   logic                    v1, v2, v3;
   logic [ADDR_W-1:0]       addr1;
   logic signed [SMP_W-1:0] smp1, smp2;
   logic signed [AMP_W-1:0] osc_c [N_LANES];
   logic signed [AMP_W-1:0] osc_r [N_LANES];
   logic [OUT_W-1:0]        prod  [N_LANES];

   nco_phase_acc #(.PHASE_W(PHASE_W), .ADDR_W(ADDR_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .step_en(in_valid), .ftw(ftw),
      .ofs(phase_ofs), .acc_q(acc), .addr(addr_now)
   );

   // stage 1: capture phase index and sample
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v1    <= 1'b0;
         addr1 <= '0;
         smp1  <= '0;
      end else begin
         v1 <= in_valid;
         if (in_valid) begin
            addr1 <= addr_now;
            smp1  <= in_sample;
         end
      end
   end

   // stage 2 sample and valid
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v2   <= 1'b0;
         smp2 <= '0;
      end else begin
         v2 <= v1;
         if (v1) smp2 <= smp1;
      end
   end

   // lane 0 = I (cosine, quarter cycle ahead), lane 1 = Q (sine)
   for (genvar k = 0; k < N_LANES; k++) begin : g_lane
      nco_sine_lut #(
         .ADDR_W(ADDR_W), .AMP_W(AMP_W), .SHIFT((k == 0) ? QUARTER : 0)
      ) u_lut (
         .addr(addr1), .value(osc_c[k])
      );

      always_ff @(posedge clk) begin
         if (!rst_n)  osc_r[k] <= '0;
         else if (v1) osc_r[k] <= osc_c[k];
      end

      nco_mix_lane #(.SMP_W(SMP_W), .AMP_W(AMP_W), .OUT_W(OUT_W)) u_mul (
         .clk(clk), .rst_n(rst_n), .en(v2), .sample(smp2),
         .osc(osc_r[k]), .prod_q(prod[k])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) v3 <= 1'b0;
      else        v3 <= v2;
   end

   assign out_valid = v3;
   assign out_i     = prod[0];
   assign out_q     = prod[1];
endmodule

// File: rtl/nco_mix_chk.sv
module nco_mix_chk #(
   parameter int PHASE_W = 32,
   parameter int OUT_W   = 18
) (
   input logic               clk,
   input logic               rst_n,
   input logic               in_valid,
   input logic [PHASE_W-1:0] ftw,
   input logic [PHASE_W-1:0] acc,
   input logic               v2,
   input logic               out_valid,
   input logic [OUT_W-1:0]   out_i,
   input logic [OUT_W-1:0]   out_q
);
   logic [1:0] age;

   always_ff @(posedge clk) begin
      if (!rst_n)          age <= '0;
      else if (age != 2'd3) age <= age + 2'd1;
   end

   AST_ACC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> acc == $past(acc) + $past(ftw)); // R3
   AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(acc)); // R4
   AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2'd3) |-> out_valid == $past(in_valid, 3)); // R5
   AST_PROD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !v2 |=> $stable(out_i) && $stable(out_q)); // R8
endmodule

bind nco_mix_top nco_mix_chk #(.PHASE_W(PHASE_W), .OUT_W(OUT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .ftw(ftw), .acc(acc),
   .v2(v2), .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
);

// File: tb/nco_mix_top_tb_top.sv
module nco_mix_top_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [15:0] in_sample = '0;
   logic [31:0] ftw = '0;
   logic [31:0] phase_ofs = '0;
   logic        out_valid;
   logic [17:0] out_i, out_q;

   int n_run = 0;
   int n_fail = 0;
   logic [31:0] acc_m = '0;

   always #2 clk = ~clk;

   nco_mix_top dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
      .ftw(ftw), .phase_ofs(phase_ofs), .out_valid(out_valid),
      .out_i(out_i), .out_q(out_q)
   );

   // {sample, tuning word, offset}
   localparam logic [79:0] VEC [8] = '{
      {16'h4000, 32'h0100_0000, 32'h0000_0000},
      {16'h7FFF, 32'h0040_0000, 32'h0000_0000},
      {16'h8000, 32'hC000_0000, 32'h3FC0_0000},
      {16'h1234, 32'hFFFF_FFFF, 32'h8000_0000},
      {16'hF000, 32'h0000_0001, 32'h4000_0000},
      {16'h0000, 32'h1357_9BDF, 32'h0000_0000},
      {16'h7FFF, 32'h8000_0000, 32'hFFC0_0000},
      {16'hC001, 32'h0ABC_DEF0, 32'h1111_1111}
   };

   function automatic int sin_m(int n);
      real r;
      r = 32767.0 * $sin(2.0 * 3.14159265358979 * (n + 0.5) / 1024.0);
      return (r >= 0.0) ? $rtoi(r + 0.5) : $rtoi(r - 0.5);
   endfunction

   function automatic logic [17:0] prod_m(logic signed [15:0] s, int osc);
      longint p;
      p = longint'(s) * longint'(osc);
      return p[31:14];
   endfunction

   task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // drive one sample, then check the product three cycles later and its hold
   task automatic one_sample(logic [15:0] s, logic [31:0] f, logic [31:0] o, string req);
      int n;
      logic [17:0] ei, eq;
      @(negedge clk);
      in_sample = s; ftw = f; phase_ofs = o; in_valid = 1'b1;
      n  = int'((acc_m + o) >> 22);
      ei = prod_m(s, sin_m((n + 256) % 1024));
      eq = prod_m(s, sin_m(n));
      acc_m = acc_m + f;
      @(negedge clk);
      in_valid = 1'b0; ftw = 32'h0765_4321; phase_ofs = 32'h5A5A_5A5A; in_sample = 16'h1357;
      @(negedge clk);
      @(negedge clk);
      check("R5", "valid", 32'(out_valid), 32'd1);
      check(req, "I", 32'(out_i), 32'(ei));
      check(req, "Q", 32'(out_q), 32'(eq));
      @(negedge clk);
      check("R5", "pulse end", 32'(out_valid), 32'd0);
      check("R8", "I hold", 32'(out_i), 32'(ei));
      check("R8", "Q hold", 32'(out_q), 32'(eq));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1", "valid", 32'(out_valid), 32'd0);
      check("R1", "I", 32'(out_i), 32'd0);
      check("R1", "Q", 32'(out_q), 32'd0);
      rst_n = 1'b1;

      // vector table: R2 R3 R4 R6 R7, entry 2 and 6 exercise R9 extremes
      for (int v = 0; v < 8; v++) begin
         one_sample(VEC[v][79:64], VEC[v][63:32], VEC[v][31:0],
                    (v == 2 || v == 6) ? "R9" : "R2/R3/R6/R7");
      end

      // R5: back-to-back and gapped valid pattern
      begin
         logic [9:0] pat;
         pat = 10'b0000111011;
         ftw = 32'h0200_0000; phase_ofs = '0;
         for (int t = 0; t < 10; t++) begin
            @(negedge clk);
            check("R5", "burst valid", 32'(out_valid), (t >= 3) ? 32'(pat[t-3]) : 32'd0);
            in_valid = pat[t];
            if (pat[t]) acc_m = acc_m + ftw;
         end
         in_valid = 1'b0;
         repeat (3) @(negedge clk);
      end
      // R3/R4: phase continuity after the burst
      one_sample(16'h2000, 32'h0000_0000, 32'h0000_0000, "R3");

      // R1: reset mid-stream clears accumulator and outputs
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check("R1", "valid after reset", 32'(out_valid), 32'd0);
      check("R1", "I after reset", 32'(out_i), 32'd0);
      rst_n = 1'b1;
      acc_m = '0;
      one_sample(16'h3000, 32'h0123_4567, 32'h0000_0000, "R1");

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule